// File: doc/BRIEF.md
# DRAM Command Spacing Guard

This block sits beside the command scheduler of one DRAM channel and decides, cycle by cycle, whether the candidate command the scheduler is offering may go out on the bus. The scheduler drives a command type, a rank and a bank. The block answers combinationally on `cand_ok`. When the scheduler actually sends the command, it raises `issue_en` in the same cycle, and the block records that event for all later decisions. All spacing is counted in DRAM clocks.

The spacing limits live in two configuration registers, reached through a small register port. The write-side register is 16 bits and holds the limits that gate WRITE commands. The read-side register is 24 bits and holds the limits that gate READ commands. Its top three bits are reserved. Internally the block keeps a saturating "cycles since event" age for each rank-bank ACTIVATE, and one age per rank for the most recent READ and the most recent WRITE. Every limit is then a simple comparison of an age against a field. One ACTIVATE age can therefore serve two different ACT-to-command limits.

The scheduler may still issue a command that was not allowed. Such an issue is still recorded, and it sets a sticky violation flag that only reset clears.

Top module: `dram_spacing_guard`

## Requirements
- R1: After reset both configuration registers read zero, `violation` is 0, and READ and WRITE candidates are allowed.
- R2: `reg_sel`=0 selects the write-side register and `reg_sel`=1 selects the read-side register. A write with `reg_we`=1 lands at the clock edge. Read data is combinational. Write-side read data has bits 23:16 at zero. Read-side bits 23:21 read zero, and writes to them are ignored.
- R3: A WRITE to a rank-bank is allowed only when at least the ACT-to-write delay (write-side bits 15:12) has passed since the ACTIVATE to that rank-bank.
- R4: A READ to a rank-bank is allowed only when at least the ACT-to-read delay (read-side bits 20:17) has passed since the ACTIVATE to that rank-bank.
- R5: A WRITE must trail the last WRITE to its own rank by the same-rank write-to-write delay (write-side bits 11:8). It must trail the last WRITE to any other rank by the different-rank write-to-write delay (write-side bits 7:4).
- R6: A WRITE must trail the last READ to any rank by the read-to-write delay (write-side bits 3:0).
- R7: A READ must trail the last WRITE to its own rank by the 5-bit same-rank write-to-read delay (read-side bits 16:12). It must trail the last WRITE to any other rank by the different-rank write-to-read delay (read-side bits 11:8).
- R8: A READ must trail the last READ to its own rank by the same-rank read-to-read delay (read-side bits 7:4). It must trail the last READ to any other rank by the different-rank read-to-read delay (read-side bits 3:0).
- R9: A delay of 0 or 1 adds no wait. With every field at 1, any command is allowed in the cycle after the command that constrains it.
- R10: When several limits apply to one candidate, `cand_ok` is high only if every one of them is met.
- R11: An issue of a READ or WRITE while `cand_ok` is low sets `violation` from the next cycle on. The flag stays set until reset, and the issued command still restarts its ages.
- R12: Command encoding on `cand_cmd` is 00 none, 01 ACTIVATE, 10 READ and 11 WRITE. ACTIVATE and none are always allowed. An ACTIVATE constrains only its own rank-bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the write-side register, 1 selects the read-side register |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data for the selected register |
| cand_cmd | input | 2 | Candidate command type |
| cand_rank | input | RANK_W | Candidate rank |
| cand_bank | input | BANK_W | Candidate bank |
| issue_en | input | 1 | Candidate is being issued this cycle |
| cand_ok | output | 1 | Candidate meets every spacing limit |
| violation | output | 1 | Sticky flag: a command was issued while not allowed |

## Verification
One fixed set of distinct limits drives a cycle-by-cycle sequence. Each field value is chosen so that a candidate is blocked by a single limit at a time: ACT-to-write, then ACT-to-read, same-rank against other-rank write spacing, and write-to-read in both rank cases. Read-to-read and read-to-write are exercised the same way. Each blocked/allowed edge therefore shows which field was compared, and which rank ages were picked as "own" and which as "other". A stretch where ACT and write spacing are already met but read-to-write still blocks shows that the limits are combined. Directed runs cover the reserved register bits, all-one delays (the next-cycle case), and a forced violation whose follow-up blocking shows that the ages were reloaded.

// File: rtl/dram_spacing_guard.sv
module dram_spacing_guard #(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 4,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [23:0]       reg_wdata,
  output logic [23:0]       reg_rdata,
  input  logic [1:0]        cand_cmd,
  input  logic [RANK_W-1:0] cand_rank,
  input  logic [BANK_W-1:0] cand_bank,
  input  logic              issue_en,
  output logic              cand_ok,
  output logic              violation
);
  localparam int AGE_W = 5;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam int NUM_RB = NUM_RANKS * NUM_BANKS;
  localparam logic [1:0] CMD_ACT = 2'b01, CMD_RD = 2'b10, CMD_WR = 2'b11;

  logic [15:0] wcfg;
  logic [20:0] rcfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcfg <= '0;
      rcfg <= '0;
    end else if (reg_we) begin
      if (reg_sel) rcfg <= reg_wdata[20:0];
      else         wcfg <= reg_wdata[15:0];
    end
  end

  assign reg_rdata = reg_sel ? {3'b000, rcfg} : {8'h00, wcfg};

  logic [AGE_W-1:0] lim_act_wr, lim_ww_same, lim_ww_diff, lim_rd_wr;
  logic [AGE_W-1:0] lim_act_rd, lim_wr_same, lim_wr_diff, lim_rr_same, lim_rr_diff;

  assign lim_act_wr  = {1'b0, wcfg[15:12]};
  assign lim_ww_same = {1'b0, wcfg[11:8]};
  assign lim_ww_diff = {1'b0, wcfg[7:4]};
  assign lim_rd_wr   = {1'b0, wcfg[3:0]};
  assign lim_act_rd  = {1'b0, rcfg[20:17]};
  assign lim_wr_same = rcfg[16:12];
  assign lim_wr_diff = {1'b0, rcfg[11:8]};
  assign lim_rr_same = {1'b0, rcfg[7:4]};
  assign lim_rr_diff = {1'b0, rcfg[3:0]};

  logic [AGE_W-1:0] act_age [NUM_RB];
  logic [AGE_W-1:0] wr_age  [NUM_RANKS];
  logic [AGE_W-1:0] rd_age  [NUM_RANKS];

  for (genvar g = 0; g < NUM_RB; g++) begin : g_rb
    wire hit = issue_en && cand_cmd == CMD_ACT &&
               int'(cand_rank) == g / NUM_BANKS && int'(cand_bank) == g % NUM_BANKS;
    always_ff @(posedge clk) begin
      if (!rst_n)                  act_age[g] <= AGE_MAX;
      else if (hit)                act_age[g] <= AGE_W'(1);
      else if (act_age[g] != AGE_MAX) act_age[g] <= act_age[g] + AGE_W'(1);
    end
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    wire own = int'(cand_rank) == r;
    always_ff @(posedge clk) begin
      if (!rst_n)                          wr_age[r] <= AGE_MAX;
      else if (issue_en && own && cand_cmd == CMD_WR) wr_age[r] <= AGE_W'(1);
      else if (wr_age[r] != AGE_MAX)       wr_age[r] <= wr_age[r] + AGE_W'(1);
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                          rd_age[r] <= AGE_MAX;
      else if (issue_en && own && cand_cmd == CMD_RD) rd_age[r] <= AGE_W'(1);
      else if (rd_age[r] != AGE_MAX)       rd_age[r] <= rd_age[r] + AGE_W'(1);
    end
  end

  logic rd_ok, wr_ok;
  logic [AGE_W-1:0] bank_age;

  always_comb begin
    bank_age = AGE_MAX;
    for (int i = 0; i < NUM_RB; i++)
      if (int'(cand_rank) == i / NUM_BANKS && int'(cand_bank) == i % NUM_BANKS)
        bank_age = act_age[i];
    rd_ok = bank_age >= lim_act_rd;
    wr_ok = bank_age >= lim_act_wr;
    for (int r = 0; r < NUM_RANKS; r++) begin
      if (int'(cand_rank) == r) begin
        if (wr_age[r] < lim_ww_same) wr_ok = 1'b0;
        if (wr_age[r] < lim_wr_same) rd_ok = 1'b0;
        if (rd_age[r] < lim_rr_same) rd_ok = 1'b0;
      end else begin
        if (wr_age[r] < lim_ww_diff) wr_ok = 1'b0;
        if (wr_age[r] < lim_wr_diff) rd_ok = 1'b0;
        if (rd_age[r] < lim_rr_diff) rd_ok = 1'b0;
      end
      if (rd_age[r] < lim_rd_wr) wr_ok = 1'b0;
    end
  end

  assign cand_ok = (cand_cmd == CMD_RD) ? rd_ok :
                   (cand_cmd == CMD_WR) ? wr_ok : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) violation <= 1'b0;
    else if (issue_en && cand_cmd[1] && !cand_ok) violation <= 1'b1;
  end
endmodule

module dram_spacing_guard_chk #(
  parameter int RANK_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic [23:0]       reg_rdata,
  input logic [1:0]        cand_cmd,
  input logic [RANK_W-1:0] cand_rank,
  input logic              issue_en,
  input logic              cand_ok,
  input logic              violation,
  input logic [15:0]       wcfg,
  input logic [20:0]       rcfg
);
  wire all_unity = wcfg[15:12] <= 4'd1 && wcfg[11:8] <= 4'd1 && wcfg[7:4] <= 4'd1 &&
                   wcfg[3:0] <= 4'd1 && rcfg[20:17] <= 4'd1 && rcfg[16:12] <= 5'd1 &&
                   rcfg[11:8] <= 4'd1 && rcfg[7:4] <= 4'd1 && rcfg[3:0] <= 4'd1;

  AST_VIOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation); // R11
  AST_VIOL_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && cand_cmd[1] && !cand_ok) |=> violation); // R11
  AST_ACT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_cmd == 2'b01) |-> cand_ok); // R12
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> reg_rdata[23:21] == 3'b000); // R2
  AST_WSIDE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> reg_rdata[23:16] == 8'h00); // R2
  AST_WW_SAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue_en && cand_cmd == 2'b11) && cand_cmd == 2'b11 &&
     cand_rank == $past(cand_rank) && wcfg[11:8] >= 4'd2) |-> !cand_ok); // R5
  AST_RR_SAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue_en && cand_cmd == 2'b10) && cand_cmd == 2'b10 &&
     cand_rank == $past(cand_rank) && rcfg[7:4] >= 4'd2) |-> !cand_ok); // R8
  AST_UNITY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    all_unity |-> cand_ok); // R9
endmodule

bind dram_spacing_guard dram_spacing_guard_chk #(.RANK_W(RANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .cand_cmd(cand_cmd), .cand_rank(cand_rank), .issue_en(issue_en),
  .cand_ok(cand_ok), .violation(violation), .wcfg(wcfg), .rcfg(rcfg)
);

// File: tb/tb_dram_spacing_guard.sv
`timescale 1ns/1ps
module tb_dram_spacing_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [23:0] reg_wdata = '0, reg_rdata;
  logic [1:0] cand_cmd = 2'b00;
  logic [0:0] cand_rank = '0;
  logic [1:0] cand_bank = '0;
  logic issue_en = 1'b0;
  logic cand_ok, violation;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_spacing_guard dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cand_cmd(cand_cmd),
    .cand_rank(cand_rank), .cand_bank(cand_bank), .issue_en(issue_en),
    .cand_ok(cand_ok), .violation(violation)
  );

  // {cmd, rank, bank, issue, expected cand_ok}; limits: wside 16'h4325, rside 21'h066242
  localparam logic [6:0] VEC [0:24] = '{
    7'b01_0_00_1_1,  // ACT r0b0
    7'b11_0_00_0_0,  // R3 act age 1 < 4
    7'b11_0_00_0_0,  // R3 act age 2
    7'b10_0_00_0_1,  // R4 act age 3 meets 3
    7'b11_0_00_0_1,  // R3 act age 4 meets 4
    7'b11_0_00_1_1,  // WRITE r0
    7'b11_0_01_0_0,  // R5 same rank age 1 < 3
    7'b11_1_00_0_1,  // R5 other rank age 2 meets 2
    7'b11_0_00_0_1,  // R5 same rank age 3 meets 3
    7'b10_1_00_0_1,  // R7 other rank age 4 meets 2
    7'b10_0_00_0_0,  // R7 same rank age 5 < 6
    7'b10_0_00_1_1,  // R7 same rank age 6 meets 6, READ r0 issued
    7'b11_1_00_0_0,  // R6 read age 1 < 5
    7'b10_0_01_0_0,  // R8 same rank age 2 < 4
    7'b10_1_01_1_1,  // R8 other rank age 3 meets 2, READ r1 issued
    7'b10_0_10_0_0,  // R8 other rank r1 age 1 < 2
    7'b11_0_00_0_0,  // R10 act and write met, r1 read age 2 < 5
    7'b11_0_00_0_0,  // R10
    7'b11_0_00_0_0,  // R10
    7'b11_0_00_0_1,  // R6 r1 read age 5 meets 5
    7'b01_1_11_1_1,  // ACT r1b3
    7'b10_1_11_0_0,  // R4 act age 1 < 3
    7'b10_1_11_0_0,  // R4
    7'b10_1_11_0_1,  // R4 act age 3 meets 3
    7'b00_0_00_0_1   // R12 no command
  };

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic r, input logic [1:0] b,
                      input logic iss, input logic exp, input string tag);
    @(negedge clk);
    cand_cmd = c; cand_rank = r; cand_bank = b; issue_en = iss;
    #1 chk(tag, {23'b0, cand_ok}, {23'b0, exp});
  endtask

  task automatic reg_write(input logic sel, input logic [23:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d; issue_en = 1'b0; cand_cmd = 2'b00;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    issue_en = 1'b0; cand_cmd = 2'b00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; issue_en = 1'b0; cand_cmd = 2'b00; reg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    reg_sel = 1'b0; #1 chk("R1 wside reset", reg_rdata, 24'h0);
    reg_sel = 1'b1; #1 chk("R1 rside reset", reg_rdata, 24'h0);
    chk("R1 violation reset", {23'b0, violation}, 24'h0);
    step(2'b10, 1'b1, 2'd2, 1'b0, 1'b1, "R1 read allowed");
    step(2'b11, 1'b0, 2'd1, 1'b0, 1'b1, "R1 write allowed");

    reg_write(1'b0, 24'hFFFFFF);
    reg_sel = 1'b0; #1 chk("R2 wside upper zero", reg_rdata, 24'h00FFFF);
    reg_write(1'b1, 24'hFFFFFF);
    reg_sel = 1'b1; #1 chk("R2 rside reserved", reg_rdata, 24'h1FFFFF);

    reg_write(1'b0, 24'h004325);
    reg_write(1'b1, 24'hE66242);
    reg_sel = 1'b1; #1 chk("R2 rside readback", reg_rdata, 24'h066242);
    reg_sel = 1'b0; #1 chk("R2 wside readback", reg_rdata, 24'h004325);

    for (int i = 0; i < 25; i++) begin
      logic [6:0] v;
      v = VEC[i];
      step(v[6:5], v[4], v[3:2], v[1], v[0],
           $sformatf("table row %0d (R3/R4/R5/R6/R7/R8/R10/R12)", i));
    end
    chk("R11 no violation yet", {23'b0, violation}, 24'h0);

    step(2'b11, 1'b0, 2'd0, 1'b1, 1'b1, "R11 lawful write");
    step(2'b11, 1'b0, 2'd0, 1'b1, 1'b0, "R11 unlawful write");
    step(2'b11, 1'b0, 2'd0, 1'b0, 1'b0, "R11 age reloaded 1");
    chk("R11 violation set", {23'b0, violation}, 24'h1);
    step(2'b11, 1'b0, 2'd0, 1'b0, 1'b0, "R11 age reloaded 2");
    step(2'b11, 1'b0, 2'd0, 1'b0, 1'b1, "R11 age reloaded 3");
    idle(); idle();
    #1 chk("R11 violation sticky", {23'b0, violation}, 24'h1);

    do_reset();
    @(negedge clk);
    #1 chk("R1 violation cleared", {23'b0, violation}, 24'h0);
    reg_sel = 1'b0; #1 chk("R1 wside cleared", reg_rdata, 24'h0);

    reg_write(1'b0, 24'h001111);
    reg_write(1'b1, 24'h021111);
    step(2'b01, 1'b0, 2'd0, 1'b1, 1'b1, "R9 act");
    step(2'b11, 1'b0, 2'd0, 1'b1, 1'b1, "R9 write after act");
    step(2'b11, 1'b1, 2'd0, 1'b1, 1'b1, "R9 write other rank");
    step(2'b10, 1'b1, 2'd0, 1'b1, 1'b1, "R9 read after write");
    step(2'b10, 1'b1, 2'd1, 1'b1, 1'b1, "R9 read after read");
    step(2'b11, 1'b0, 2'd0, 1'b1, 1'b1, "R9 write after read");
    step(2'b01, 1'b1, 2'd3, 1'b1, 1'b1, "R12 act always ok");
    idle();
    #1 chk("R9 no violation", {23'b0, violation}, 24'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule